// File: doc/BRIEF.md
# Segment Data Latch and Level Selector

This block sits between a display memory and the analog output stage of a passive-matrix liquid-crystal panel. Once per line (common period) it captures one row of segment bits from the memory read port into a latch. It then converts each latched bit into a 2-bit code that chooses one of four drive voltages for its segment pin. The chosen voltage depends on the bit, on the frame polarity signal that alternates to keep the liquid crystal free of a DC bias, and on two display controls.

The two controls are display-enable and force-all-lit. They act only after the latch, on the path from latch to level code. They therefore change what the panel shows without changing the memory. They also leave the latch as it is, so the previous picture comes back as soon as a control is released. The level codes are registered and update only on a line-clock edge, which lets the analog multiplexers switch once per line boundary.

Top module: `seg_latch_drv`

## Requirements
- R1: While reset is asserted, and until the first line-clock edge after its synchronous release, every segment outputs code 1. The latch is cleared to all zeros.
- R2: On a rising line-clock edge with `load_en` high, the latch captures `ram_data`. With `load_en` low, the latch keeps its value whatever `ram_data` does.
- R3: When the display is enabled and `frame_pol` is 0, a lit segment outputs code 2 and an unlit segment outputs code 1.
- R4: When the display is enabled and `frame_pol` is 1, a lit segment outputs code 0 and an unlit segment outputs code 3.
- R5: With `disp_on` low, every segment outputs the unlit code for the current polarity (1 or 3). This holds regardless of latched data and of `all_on`, so disabling the display takes priority over force-all-lit.
- R6: With `disp_on` high and `all_on` high, every segment outputs the lit code for the current polarity (2 or 0), regardless of latched data.
- R7: Segment i uses latch bit i, which comes from `ram_data[i]`, and drives `seg_lvl[2i+1:2i]`. Its code is registered from the latch contents and the control inputs sampled at a line-clock edge. Data loaded at one edge therefore appears on the outputs at the next edge.
- R8: Toggling `disp_on` or `all_on` does not modify the latch. When both controls return to normal, the previously latched pattern reappears without any new load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock; rising edge marks a line boundary |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Captures `ram_data` into the latch at the next rising edge |
| ram_data | input | NUM_SEG | One row of segment bits from display memory |
| frame_pol | input | 1 | Frame polarity that selects the level pair |
| disp_on | input | 1 | Display enable; low forces every segment unlit |
| all_on | input | 1 | Forces every segment lit while the display is enabled |
| seg_lvl | output | 2*NUM_SEG | Per-segment 2-bit drive-level code, segment i at bits 2i+1:2i |

## Verification
The bench builds the block with its default of 80 segments and a two-stage reset synchronizer. That size covers the full row width, so patterns with different top and bottom halves show whether segment indices map correctly to their bit fields. It also exposes the synchronizer's release delay, so the bench can check that outputs hold the reset code through it. Back-to-back loads with `load_en` held high put the one-line latency between latch and output in reach. The control overrides are checked in both polarities, and the bench then confirms that the hidden latch contents survive them.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

  typedef logic [1:0] lvl_code_t;

  // Level pair for polarity 0 and polarity 1
  localparam lvl_code_t LVL_LIT_P0   = 2'd2;
  localparam lvl_code_t LVL_UNLIT_P0 = 2'd1;
  localparam lvl_code_t LVL_LIT_P1   = 2'd0;
  localparam lvl_code_t LVL_UNLIT_P1 = 2'd3;

  function automatic lvl_code_t seg_code(input logic lit, input logic pol);
    lvl_code_t c;
    if (pol) c = lit ? LVL_LIT_P1 : LVL_UNLIT_P1;
    else     c = lit ? LVL_LIT_P0 : LVL_UNLIT_P0;
    return c;
  endfunction

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/seg_row_latch.sv
module seg_row_latch #(
  parameter int NUM_SEG = 80
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               load_en,
  input  logic [NUM_SEG-1:0] row_in,
  output logic [NUM_SEG-1:0] row_q
);
  logic [NUM_SEG-1:0] row_d;

  always_comb begin
    row_d = row_q;
    if (load_en) row_d = row_in;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) row_q <= '0;
    else         row_q <= row_d;
  end
endmodule

// File: rtl/seg_level_sel.sv
module seg_level_sel
  import seg_drv_pkg::*;
#(
  parameter int NUM_SEG = 80
) (
  input  logic                 clk,
  input  logic                 rst_sn,
  input  logic [NUM_SEG-1:0]   row_q,
  input  logic                 frame_pol,
  input  logic                 disp_on,
  input  logic                 all_on,
  output logic [2*NUM_SEG-1:0] lvl_q
);
  localparam int LW = $bits(lvl_code_t);

  genvar i;
  generate
    for (i = 0; i < NUM_SEG; i++) begin : g_seg
      logic      lit;
      lvl_code_t code_d;
      lvl_code_t code_q;

      always_comb begin
        lit    = disp_on & (all_on | row_q[i]);
        code_d = seg_code(lit, frame_pol);
      end

      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) code_q <= LVL_UNLIT_P0;
        else         code_q <= code_d;
      end

      assign lvl_q[i*LW +: LW] = code_q;
    end
  endgenerate
endmodule

// File: rtl/seg_latch_drv.sv
module seg_latch_drv #(
  parameter int NUM_SEG     = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [NUM_SEG-1:0]   ram_data,
  input  logic                 frame_pol,
  input  logic                 disp_on,
  input  logic                 all_on,
  output logic [2*NUM_SEG-1:0] seg_lvl
);
  logic               rst_sn;
  logic [NUM_SEG-1:0] row_q;

  seg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  seg_row_latch #(.NUM_SEG(NUM_SEG)) u_latch (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .load_en (load_en),
    .row_in  (ram_data),
    .row_q   (row_q)
  );

  seg_level_sel #(.NUM_SEG(NUM_SEG)) u_sel (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .row_q     (row_q),
    .frame_pol (frame_pol),
    .disp_on   (disp_on),
    .all_on    (all_on),
    .lvl_q     (seg_lvl)
  );
endmodule

// File: rtl/seg_latch_drv_chk.sv
module seg_latch_drv_chk #(
  parameter int NUM_SEG = 80
) (
  input logic                 clk,
  input logic                 rst_sn,
  input logic                 load_en,
  input logic [NUM_SEG-1:0]   ram_data,
  input logic                 frame_pol,
  input logic                 disp_on,
  input logic                 all_on,
  input logic [NUM_SEG-1:0]   row_q,
  input logic [2*NUM_SEG-1:0] seg_lvl
);
  localparam logic [2*NUM_SEG-1:0] ALL_P0_UNLIT = {NUM_SEG{2'b01}};
  localparam logic [2*NUM_SEG-1:0] ALL_P1_UNLIT = {NUM_SEG{2'b11}};
  localparam logic [2*NUM_SEG-1:0] ALL_P0_LIT   = {NUM_SEG{2'b10}};
  localparam logic [2*NUM_SEG-1:0] ALL_P1_LIT   = {NUM_SEG{2'b00}};

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(load_en)) |-> (row_q == $past(ram_data)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && !$past(load_en)) |-> (row_q == $past(row_q)));

  a_r5_off_unlit: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && !$past(disp_on)) |->
      (seg_lvl == ($past(frame_pol) ? ALL_P1_UNLIT : ALL_P0_UNLIT)));

  a_r6_all_lit: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(disp_on) && $past(all_on)) |->
      (seg_lvl == ($past(frame_pol) ? ALL_P1_LIT : ALL_P0_LIT)));

  a_r1_reset_code: assert property (@(posedge clk)
    (!rst_sn) |=> (seg_lvl == ALL_P0_UNLIT));
endmodule

bind seg_latch_drv seg_latch_drv_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .load_en   (load_en),
  .ram_data  (ram_data),
  .frame_pol (frame_pol),
  .disp_on   (disp_on),
  .all_on    (all_on),
  .row_q     (row_q),
  .seg_lvl   (seg_lvl)
);

// File: tb/sim_seg_latch_drv.sv
`timescale 1ns/1ps
module sim_seg_latch_drv;
  localparam int N = 80;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           load_en;
  logic [N-1:0]   ram_data;
  logic           frame_pol;
  logic           disp_on;
  logic           all_on;
  logic [2*N-1:0] seg_lvl;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  localparam logic [N-1:0] PAT_A = {{40{1'b1}}, {20{2'b01}}};
  localparam logic [N-1:0] PAT_B = {{20{2'b10}}, {40{1'b0}}};
  localparam logic [N-1:0] PAT_C = {{10{4'b1100}}, {10{4'b0011}}};

  always #10 clk = ~clk;

  seg_latch_drv #(.NUM_SEG(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .ram_data(ram_data),
    .frame_pol(frame_pol), .disp_on(disp_on), .all_on(all_on),
    .seg_lvl(seg_lvl)
  );

  function automatic logic [2*N-1:0] expect_lvl(input logic [N-1:0] d,
      input logic on, input logic all, input logic pol);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) begin
      logic lit;
      lit = on & (all | d[i]);
      if (pol) v[2*i +: 2] = lit ? 2'd0 : 2'd3;
      else     v[2*i +: 2] = lit ? 2'd2 : 2'd1;
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [2*N-1:0] exp);
    n_tests++;
    if (seg_lvl !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, seg_lvl, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic ld, input logic [N-1:0] d,
      input logic pol, input logic on, input logic all);
    @(negedge clk);
    load_en = ld; ram_data = d; frame_pol = pol; disp_on = on; all_on = all;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load_en = 1'b0; ram_data = '1; frame_pol = 1'b1;
    disp_on = 1'b1; all_on = 1'b1;
    edge_step(); edge_step();
    check("R1 during reset", {N{2'b01}});
    drive(1'b0, '1, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    edge_step();
    check("R1 synchronizer delay", {N{2'b01}});
    edge_step(); edge_step();
    check("R1 cleared latch pol0", {N{2'b01}});
    drive(1'b0, '1, 1'b1, 1'b1, 1'b0);
    edge_step();
    check("R1 cleared latch pol1", {N{2'b11}});
  endtask

  task automatic t_load_latency();
    drive(1'b1, PAT_A, 1'b0, 1'b1, 1'b0);
    edge_step();
    check("R7 no change on load edge", expect_lvl('0, 1'b1, 1'b0, 1'b0));
    drive(1'b0, ~PAT_A, 1'b0, 1'b1, 1'b0);
    edge_step();
    check("R3 R7 pattern A pol0", expect_lvl(PAT_A, 1'b1, 1'b0, 1'b0));
  endtask

  task automatic t_pol1();
    drive(1'b0, PAT_B, 1'b1, 1'b1, 1'b0);
    edge_step();
    check("R4 pattern A pol1", expect_lvl(PAT_A, 1'b1, 1'b0, 1'b1));
  endtask

  task automatic t_hold();
    drive(1'b0, PAT_B, 1'b0, 1'b1, 1'b0);
    edge_step(); edge_step();
    check("R2 hold with load low", expect_lvl(PAT_A, 1'b1, 1'b0, 1'b0));
  endtask

  task automatic t_off();
    drive(1'b0, PAT_B, 1'b0, 1'b0, 1'b1);
    edge_step();
    check("R5 off beats all_on pol0", {N{2'b01}});
    drive(1'b0, PAT_B, 1'b1, 1'b0, 1'b0);
    edge_step();
    check("R5 off pol1", {N{2'b11}});
  endtask

  task automatic t_all_on();
    drive(1'b0, PAT_B, 1'b0, 1'b1, 1'b1);
    edge_step();
    check("R6 all lit pol0", {N{2'b10}});
    drive(1'b0, PAT_B, 1'b1, 1'b1, 1'b1);
    edge_step();
    check("R6 all lit pol1", {N{2'b00}});
  endtask

  task automatic t_restore();
    drive(1'b0, PAT_C, 1'b1, 1'b1, 1'b0);
    edge_step();
    check("R8 latch survives overrides", expect_lvl(PAT_A, 1'b1, 1'b0, 1'b1));
  endtask

  task automatic t_stream();
    drive(1'b1, PAT_B, 1'b0, 1'b1, 1'b0);
    edge_step();
    drive(1'b1, PAT_C, 1'b0, 1'b1, 1'b0);
    edge_step();
    check("R7 stream B", expect_lvl(PAT_B, 1'b1, 1'b0, 1'b0));
    drive(1'b1, '1, 1'b1, 1'b1, 1'b0);
    edge_step();
    check("R7 stream C", expect_lvl(PAT_C, 1'b1, 1'b0, 1'b1));
    drive(1'b0, '0, 1'b1, 1'b1, 1'b0);
    edge_step();
    check("R4 stream all ones", {N{2'b00}});
  endtask

  initial begin
    t_reset();
    t_load_latency();
    t_pol1();
    t_hold();
    t_off();
    t_all_on();
    t_restore();
    t_stream();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule